// File: doc/BRIEF.md
# Burst Address Sequencer With Mode Select

This block produces the word address for each beat of a four-beat burst in a synchronous burst memory. At a clock edge it can capture an external address through either of two active-low address strobes: a processor strobe and a controller strobe. It then walks the two lowest address bits through the burst while the upper bits stay as they were captured. An active-low advance input steps the burst and a high advance suspends it. Three chip enables decide whether a strobe cycle selects the block or deselects it. The enables are one primary active-low enable, one active-high enable and one further active-low enable.

Two burst orders are supported. With the mode input low, the low bits count upward from the start offset and wrap modulo four. With the mode input high, the low bits are the start offset XOR the beat count. The mode is captured at each load. The sequencer is a four-state machine:

- `ST_DESEL`: not selected.
- `ST_FIRST`: first beat after a load.
- `ST_STEP`: burst advanced.
- `ST_HOLD`: burst suspended.

Each edge decodes one of four commands: `CMD_LOAD`, `CMD_DROP`, `CMD_ADV` or `CMD_WAIT`. The transitions are:

- `CMD_LOAD` goes to `ST_FIRST` from any state.
- `CMD_DROP` goes to `ST_DESEL` from any state.
- `CMD_ADV` goes to `ST_STEP` from any selected state and keeps `ST_DESEL` in place.
- `CMD_WAIT` goes to `ST_HOLD` from any selected state and keeps `ST_DESEL` in place.

Top module: `burst_addr_seq`

## Requirements
- R1: An active-low synchronous reset forces addr_out to all zeros and selected to 0 after the edge, and the block stays deselected until a load.
- R2: A strobe cycle loads when three conditions hold: ce_n is low, ce_hi is high and ce_lo_n is low. The strobe cycle is either ps_n low, or cs_n low with the processor strobe not in effect. After that edge addr_out equals the sampled addr_in and selected is 1.
- R3: With the mode captured as 0 (linear), each advance adds one to the low two address bits modulo 4. A start of 01 gives 01, 10, 11, 00.
- R4: With the mode captured as 1 (interleaved), the low two bits are the start offset XOR the beat count (0 to 3). A start of 10 gives 10, 11, 00, 01, and a start of 11 gives 11, 10, 01, 00.
- R5: The upper address bits (all bits above bit 1) do not change in any cycle that is not a load.
- R6: ps_n low while ce_n is high is ignored. With cs_n high, the address and selected keep their values or follow adv_n as if no strobe were present.
- R7: Some strobe cycles deselect the block: selected becomes 0 and addr_out keeps its value. This happens when cs_n is low with any enable inactive, or when ps_n is low with ce_n low but ce_hi low or ce_lo_n high.
- R8: In a cycle with both strobes high, the chip enables have no effect.
- R9: In a cycle with no strobe in effect, adv_n high holds addr_out. While deselected, addr_out holds regardless of adv_n.
- R10: A strobe load takes priority over advance in the same cycle.
- R11: The mode input is sampled only at a load. A change in the middle of a burst affects only the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address sampled at a load |
| ps_n | input | 1 | Processor address strobe, active low, gated by ce_n |
| cs_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Tertiary chip enable, active low |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst address |
| selected | output | 1 | Block selected by the last strobe decision |

## Verification
A strobe load and a burst advance can be requested in the same cycle. The bench provokes this by holding adv_n low together with a strobe. It then judges that addr_out equals the freshly sampled address rather than the next beat. A second collision puts an ignored processor strobe (ce_n high) and an active controller strobe in the same cycle. In that case the block must deselect without loading, and addr_out must stay at its previous value.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_FIRST = 2'd1,
        ST_STEP  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_WAIT = 2'd0,
        CMD_ADV  = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_DROP = 2'd3
    } seq_cmd_t;

endpackage

// File: rtl/bas_decode.sv
module bas_decode
    import bas_pkg::*;
(
    input  logic     ps_n,
    input  logic     cs_n,
    input  logic     adv_n,
    input  logic     ce_n,
    input  logic     ce_hi,
    input  logic     ce_lo_n,
    output seq_cmd_t cmd
);

    logic en_all;
    logic ps_live;

    // Enables are only looked at when a strobe is in effect (R8)
    assign en_all  = !ce_n && ce_hi && !ce_lo_n;
    // Processor strobe is masked by the primary enable (R6)
    assign ps_live = !ps_n && !ce_n;

    always_comb begin
        // A strobe outranks advance (R10)
        if (ps_live || !cs_n) begin
            cmd = en_all ? CMD_LOAD : CMD_DROP;
        end else begin
            cmd = adv_n ? CMD_WAIT : CMD_ADV;
        end
    end

endmodule

// File: rtl/bas_fsm.sv
module bas_fsm
    import bas_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  seq_cmd_t cmd,
    output logic     load_en,
    output logic     step_en,
    output logic     selected
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        step_en = 1'b0;
        unique case (cmd)
            CMD_LOAD: begin
                state_d = ST_FIRST;
                load_en = 1'b1;
            end
            CMD_DROP: begin
                state_d = ST_DESEL;
            end
            CMD_ADV: begin
                if (state_q != ST_DESEL) begin
                    state_d = ST_STEP;
                    step_en = 1'b1;
                end
            end
            CMD_WAIT: begin
                if (state_q != ST_DESEL) begin
                    state_d = ST_HOLD;
                end
            end
        endcase
    end

    assign selected = (state_q != ST_DESEL);

endmodule

// File: rtl/bas_beat_gen.sv
module bas_beat_gen #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mode_ilv,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0]  start_q;
    logic [BEAT_W-1:0]  cnt_q;
    logic               ilv_q;
    logic [BEAT_W-1:0]  lin_off;
    logic [BEAT_W-1:0]  ilv_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
        end else if (load_en) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            cnt_q   <= '0;
            ilv_q   <= mode_ilv;  // mode captured per burst (R11)
        end else if (step_en) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Linear order wraps modulo 2**BEAT_W (R3)
    assign lin_off = start_q + cnt_q;

    // Interleaved order flips start bits by the beat count (R4)
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_off[b] = start_q[b] ^ cnt_q[b];
    end

    assign addr_out = {upper_q, (ilv_q ? ilv_off : lin_off)};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ps_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              mode_ilv,
    output logic [ADDR_W-1:0] addr_out,
    output logic              selected
);

    seq_cmd_t cmd;
    logic     load_en;
    logic     step_en;

    bas_decode u_decode (
        .ps_n    (ps_n),
        .cs_n    (cs_n),
        .adv_n   (adv_n),
        .ce_n    (ce_n),
        .ce_hi   (ce_hi),
        .ce_lo_n (ce_lo_n),
        .cmd     (cmd)
    );

    bas_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_en  (load_en),
        .step_en  (step_en),
        .selected (selected)
    );

    bas_beat_gen #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .step_en  (step_en),
        .addr_in  (addr_in),
        .mode_ilv (mode_ilv),
        .addr_out (addr_out)
    );

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ps_n,
    input logic              cs_n,
    input logic              adv_n,
    input logic              ce_n,
    input logic              ce_hi,
    input logic              ce_lo_n,
    input logic [ADDR_W-1:0] addr_out,
    input logic              selected
);

    logic all_on;
    logic no_strobe;

    assign all_on    = !ce_n && ce_hi && !ce_lo_n;
    assign no_strobe = (ps_n || ce_n) && cs_n;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n && all_on) |=> (addr_out == $past(addr_in)) && selected);

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        no_strobe |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    assert_ps_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n && ce_n && cs_n) |=> selected == $past(selected));

    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !all_on) |=> !selected && $stable(addr_out));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && adv_n) |=> $stable(addr_out));

    assert_desel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !selected) |=> $stable(addr_out) && !selected);

endmodule

bind burst_addr_seq bas_checker #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_bas_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_in  (addr_in),
    .ps_n     (ps_n),
    .cs_n     (cs_n),
    .adv_n    (adv_n),
    .ce_n     (ce_n),
    .ce_hi    (ce_hi),
    .ce_lo_n  (ce_lo_n),
    .addr_out (addr_out),
    .selected (selected)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int AW = 17;
    localparam int NV = 25;

    typedef struct packed {
        logic          ps_n;
        logic          cs_n;
        logic          adv_n;
        logic          ce_n;
        logic          ce_hi;
        logic          ce_lo_n;
        logic          mode;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp_addr;
        logic          exp_sel;
        logic [3:0]    req;
    } vec_t;

    function automatic vec_t mk(logic ps, logic cs, logic adv, logic cen, logic ceh,
                                logic cel, logic md, logic [AW-1:0] a,
                                logic [AW-1:0] ea, logic es, logic [3:0] rq);
        mk = '{ps, cs, adv, cen, ceh, cel, md, a, ea, es, rq};
    endfunction

    localparam vec_t VECS [NV] = '{
        mk(0,1,1, 0,1,0, 0, 17'h1A5C1, 17'h1A5C1, 1, 2),  // R2 load via ps
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h1A5C2, 1, 3),  // R3 linear
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h1A5C3, 1, 3),  // R3
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h1A5C0, 1, 5),  // R5 wrap, upper fixed
        mk(1,1,1, 0,1,0, 0, 17'h00000, 17'h1A5C0, 1, 9),  // R9 suspend
        mk(1,0,1, 0,1,0, 1, 17'h0F00E, 17'h0F00E, 1, 2),  // R2 load via cs
        mk(1,1,0, 0,1,0, 1, 17'h00000, 17'h0F00F, 1, 4),  // R4 interleaved
        mk(1,1,0, 0,1,0, 1, 17'h00000, 17'h0F00C, 1, 4),  // R4
        mk(1,1,0, 0,1,0, 1, 17'h00000, 17'h0F00D, 1, 4),  // R4
        mk(0,1,1, 1,1,0, 0, 17'h12345, 17'h0F00D, 1, 6),  // R6 ps masked
        mk(0,0,1, 1,1,0, 0, 17'h12345, 17'h0F00D, 0, 7),  // R7 cs deselects
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h0F00D, 0, 9),  // R9 deselected hold
        mk(0,1,1, 0,1,0, 1, 17'h00003, 17'h00003, 1, 2),  // R2
        mk(1,1,0, 0,1,0, 1, 17'h00000, 17'h00002, 1, 4),  // R4 from 11
        mk(1,1,0, 1,0,1, 1, 17'h00000, 17'h00001, 1, 8),  // R8 enables ignored
        mk(0,1,1, 0,0,0, 1, 17'h11111, 17'h00001, 0, 7),  // R7 ps with ce_hi low
        mk(1,0,1, 0,1,0, 0, 17'h1FFFF, 17'h1FFFF, 1, 2),  // R2
        mk(1,1,0, 0,1,0, 1, 17'h00000, 17'h1FFFC, 1, 11), // R11 mode change ignored
        mk(0,0,1, 0,1,0, 1, 17'h0AAA2, 17'h0AAA2, 1, 2),  // R2 both strobes
        mk(1,0,0, 0,1,0, 0, 17'h0AAA1, 17'h0AAA1, 1, 10), // R10 load beats advance
        mk(1,1,0, 0,1,0, 1, 17'h00000, 17'h0AAA2, 1, 11), // R11 still linear
        mk(0,1,1, 0,1,0, 1, 17'h05550, 17'h05550, 1, 2),  // R2
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h05551, 1, 4),  // R4 from 00
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h05552, 1, 4),  // R4
        mk(1,1,0, 0,1,0, 0, 17'h00000, 17'h05553, 1, 4)   // R4
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          ps_n, cs_n, adv_n, ce_n, ce_hi, ce_lo_n, mode_ilv;
    logic [AW-1:0] addr_out;
    logic          selected;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (addr_in),
        .ps_n     (ps_n),
        .cs_n     (cs_n),
        .adv_n    (adv_n),
        .ce_n     (ce_n),
        .ce_hi    (ce_hi),
        .ce_lo_n  (ce_lo_n),
        .mode_ilv (mode_ilv),
        .addr_out (addr_out),
        .selected (selected)
    );

    task automatic check(string req, logic [AW:0] act, logic [AW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual {sel,addr}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        @(negedge clk);
        ps_n = v.ps_n; cs_n = v.cs_n; adv_n = v.adv_n;
        ce_n = v.ce_n; ce_hi = v.ce_hi; ce_lo_n = v.ce_lo_n;
        mode_ilv = v.mode; addr_in = v.addr;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ps_n = 1; cs_n = 1; adv_n = 1; ce_n = 0; ce_hi = 1; ce_lo_n = 0;
        mode_ilv = 0; addr_in = 17'h1F0F0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", {selected, addr_out}, {1'b0, 17'h0});
        @(negedge clk);
        rst_n = 1'b1;

        // R1: advance after reset leaves the block idle
        drive(mk(1,1,0, 0,1,0, 0, 17'h0, 17'h0, 0, 1));
        check("R1 idle after reset", {selected, addr_out}, {1'b0, 17'h0});

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  {selected, addr_out}, {VECS[i].exp_sel, VECS[i].exp_addr});
        end

        // R6 and R7 together: masked ps plus active cs with ce_n high
        drive(mk(0,1,1, 0,1,0, 0, 17'h13579, 17'h13579, 1, 2));
        drive(mk(0,0,0, 1,1,0, 0, 17'h02468, 17'h13579, 0, 7));
        check("R7 masked ps with cs deselects", {selected, addr_out}, {1'b0, 17'h13579});

        // R1: reset in the middle of a burst
        drive(mk(1,1,0, 0,1,0, 0, 17'h0, 17'h0, 0, 1));
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-burst", {selected, addr_out}, {1'b0, 17'h0});
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule